// File: doc/BRIEF.md
# Two-Voice Square-Wave Tune Player

This block plays short stored tunes as two square-wave voices that sound at once. The melody comes out on `left_out` and the bass line on `right_out`. Each output is a single bit that toggles at the pitch of the current note. Each voice walks its own small table of 8-bit note words. Each word gives a pitch class, a flag that lifts the note one octave, and a length code. A tempo prescaler divides the system clock into sixteenth-note beats. A second divider per voice turns each note's pitch into a half-period count in clock cycles.

`song_sel` picks the tune and `octave_sel` moves both voices across four octaves while they play. Both voices always start together. They start together after reset and after a change of `song_sel`. They also start together once both have reached the end of their tables. A melody and a bass line of unequal lengths therefore never drift apart.

Top module: `tune_player`

## Requirements
- R1: While `rst_n` is low both outputs are low. At the first rising clock edge after `rst_n` goes high, both voices start the first note of the selected tune.
- R2: A note word carries the pitch class in bits [7:4], the lift-one-octave flag in bit 3 and the length code in bits [2:0]. The value 8'hFF ends a voice's table.
- R3: Length codes 0 to 7 give 1, 2, 3, 4, 6, 8, 12 and 16 beats. A note sounds for that many beats. One silent beat then follows before the next word is taken.
- R4: A beat is one clock cycle in every `TICK_DIV` cycles. The beat count restarts whenever the voices restart, so the first beat boundary falls `TICK_DIV` cycles after a restart.
- R5: Pitch classes 12 to 15 are rests. The voice's output stays low for the rest's length.
- R6: The half period in cycles is ((B >> `DIV_SHIFT`) >> (octave_sel + lift flag)), and never less than 2. The output toggles every half period, starting low at the start of the note. B is the base count for pitch classes 0 to 11: 382204, 360750, 340507, 321419, 303361, 286336, 270270, 255102, 240778, 227273, 214518, 202478.
- R7: A voice that reaches the end word keeps its output low until the other voice has also reached its end.
- R8: In the clock cycle after both voices hold at their end words, both restart from their first notes together.
- R9: When `song_sel` differs from its value in the previous cycle, both voices and the beat count restart at that edge, even in the middle of a note.
- R10: A change of `octave_sel` during a note changes that note's pitch. It does not restart the note and does not change its timing.
- R11: Tune 0 melody is 07 4B C2 79 FF and its bass is 05 95 FF. Tune 1 melody is 26 FF and its bass is B4 50 E0 33 FF. All words are hexadecimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| song_sel | input | 1 | Chooses the stored tune |
| octave_sel | input | 2 | Octave shift, 0 is lowest |
| left_out | output | 1 | Melody square wave |
| right_out | output | 1 | Bass square wave |

## Verification
Both voices of each tune are followed beat by beat through whole passes. Windows inside sounding notes must show toggles. Rests, the silent beat after each note and the time a voice waits at its end must be low and quiet. A wrong length code, a missing gap or a voice that fails to wait shows up as a window at the wrong place. Tune switches come at random moments, often in the middle of a note, which separates a real restart from a voice that simply carries on. Edge spacing is measured under random octave settings, including the lifted note and changes made in the middle of a note. This separates a wrong shift, a lift flag that is ignored, or a pitch that fails to follow the octave input from correct division.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [1:0] {PH_SOUND, PH_GAP, PH_DONE} phase_t;

  localparam logic [7:0] END_WORD = 8'hFF;
  localparam int         HALF_W   = 19;
  localparam int         LEN_W    = 5;

  function automatic logic [3:0] pitch_of(input logic [7:0] w);
    return w[7:4];
  endfunction

  function automatic logic lift_of(input logic [7:0] w);
    return w[3];
  endfunction

  function automatic logic [LEN_W-1:0] beats_of(input logic [7:0] w);
    logic [LEN_W-1:0] b;
    case (w[2:0])
      3'd0:    b = 5'd1;
      3'd1:    b = 5'd2;
      3'd2:    b = 5'd3;
      3'd3:    b = 5'd4;
      3'd4:    b = 5'd6;
      3'd5:    b = 5'd8;
      3'd6:    b = 5'd12;
      default: b = 5'd16;
    endcase
    return b;
  endfunction

  function automatic logic is_rest(input logic [7:0] w);
    return w[7:4] >= 4'd12;
  endfunction

  // lowest-octave half periods at a 50 MHz clock
  function automatic logic [HALF_W-1:0] base_half(input logic [3:0] pc);
    logic [HALF_W-1:0] h;
    case (pc)
      4'd0:    h = 19'd382204;
      4'd1:    h = 19'd360750;
      4'd2:    h = 19'd340507;
      4'd3:    h = 19'd321419;
      4'd4:    h = 19'd303361;
      4'd5:    h = 19'd286336;
      4'd6:    h = 19'd270270;
      4'd7:    h = 19'd255102;
      4'd8:    h = 19'd240778;
      4'd9:    h = 19'd227273;
      4'd10:   h = 19'd214518;
      default: h = 19'd202478;
    endcase
    return h;
  endfunction

  function automatic logic [HALF_W-1:0] half_cycles(input logic [3:0] pc,
                                                    input logic       lift,
                                                    input logic [1:0] oct,
                                                    input int         shift);
    logic [HALF_W-1:0] h;
    logic [2:0]        steps;
    steps = {1'b0, oct} + {2'b00, lift};
    h = base_half(pc) >> shift;
    h = h >> steps;
    if (h < 19'd2) h = 19'd2;
    return h;
  endfunction

  function automatic logic [7:0] tune_word(input logic       song,
                                          input logic       voice,
                                          input logic [2:0] idx);
    logic [7:0] w;
    case ({song, voice, idx})
      5'b0_0_000: w = 8'h07;
      5'b0_0_001: w = 8'h4B;
      5'b0_0_010: w = 8'hC2;
      5'b0_0_011: w = 8'h79;
      5'b0_1_000: w = 8'h05;
      5'b0_1_001: w = 8'h95;
      5'b1_0_000: w = 8'h26;
      5'b1_1_000: w = 8'hB4;
      5'b1_1_001: w = 8'h50;
      5'b1_1_010: w = 8'hE0;
      5'b1_1_011: w = 8'h33;
      default:    w = END_WORD;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tempo_tick.sv
module tempo_tick #(
  parameter int DIV = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/square_tone.sv
module square_tone #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         enable,
  input  logic [W-1:0] half,
  output logic         wave
);
  logic [W-1:0] cnt;
  logic         flip;

  // compare with >= so a shorter half period after an octave change takes effect at once
  assign flip = (cnt >= half - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !enable) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (flip) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/note_voice.sv
module note_voice
  import tune_pkg::*;
#(
  parameter int VOICE     = 0,
  parameter int IDX_W     = 3,
  parameter int DIV_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic       song,
  input  logic [1:0] octave,
  output logic       wave,
  output logic       sounding,
  output logic       done,
  output logic       at_start
);
  phase_t            ph;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [LEN_W-1:0]  remain;
  logic [7:0]        word;
  logic [HALF_W-1:0] half;
  logic              load;

  // one table read: the current note while sounding, the next word while loading
  assign load   = restart || (tick && ph == PH_GAP);
  assign rd_idx = restart ? '0 : ((ph == PH_GAP) ? IDX_W'(idx + 1'b1) : idx);
  assign word   = tune_word(song, 1'(VOICE), 3'(rd_idx));

  assign sounding = (ph == PH_SOUND) && !is_rest(word);
  assign done     = (ph == PH_DONE);
  assign at_start = (idx == '0);
  assign half     = half_cycles(pitch_of(word), lift_of(word), octave, DIV_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_DONE;
      idx    <= '0;
      remain <= '0;
    end else if (load) begin
      idx    <= rd_idx;
      remain <= beats_of(word);
      ph     <= (word == END_WORD) ? PH_DONE : PH_SOUND;
    end else if (tick && ph == PH_SOUND) begin
      if (remain <= LEN_W'(1)) ph <= PH_GAP;
      else                     remain <= remain - 1'b1;
    end
  end

  square_tone #(.W(HALF_W)) u_tone (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (restart),
    .enable (sounding),
    .half   (half),
    .wave   (wave)
  );
endmodule

// File: rtl/tune_player.sv
module tune_player #(
  parameter int TICK_DIV  = 6_250_000,
  parameter int DIV_SHIFT = 0,
  parameter int IDX_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       song_sel,
  input  logic [1:0] octave_sel,
  output logic       left_out,
  output logic       right_out
);
  localparam int NV = 2;

  logic          song_q;
  logic          beat;
  logic          tune_restart;
  logic [NV-1:0] voice_snd;
  logic [NV-1:0] voice_done;
  logic [NV-1:0] voice_start;
  logic [NV-1:0] voice_wave;

  // a new selection, or both voices parked at their end words, starts everything over
  assign tune_restart = (song_sel != song_q) || (&voice_done);

  always_ff @(posedge clk) begin
    if (!rst_n) song_q <= 1'b0;
    else        song_q <= song_sel;
  end

  tempo_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tune_restart),
    .tick  (beat)
  );

  for (genvar v = 0; v < NV; v++) begin : g_voice
    note_voice #(
      .VOICE     (v),
      .IDX_W     (IDX_W),
      .DIV_SHIFT (DIV_SHIFT)
    ) u_voice (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (beat),
      .restart  (tune_restart),
      .song     (song_sel),
      .octave   (octave_sel),
      .wave     (voice_wave[v]),
      .sounding (voice_snd[v]),
      .done     (voice_done[v]),
      .at_start (voice_start[v])
    );
  end

  assign left_out  = voice_wave[0];
  assign right_out = voice_wave[1];
endmodule

// File: rtl/tune_player_chk.sv
module tune_player_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       song_sel,
  input logic       beat,
  input logic       tune_restart,
  input logic [1:0] voice_snd,
  input logic [1:0] voice_done,
  input logic [1:0] voice_start,
  input logic       left_out,
  input logic       right_out
);
  // R4: a beat lasts exactly one cycle
  a_r4_beat_single: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> !beat);

  // R9: any change of tune selection triggers a restart
  a_r9_song_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(song_sel) |-> tune_restart);

  // R8: a restart puts both voices back on their first word
  a_r8_both_first: assert property (@(posedge clk) disable iff (!rst_n)
    tune_restart |=> (voice_start[0] && voice_start[1]));

  // R5: a silent melody voice drives its output low next cycle
  a_r5_left_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !voice_snd[0] |=> !left_out);

  // R5: same for the bass voice
  a_r5_right_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !voice_snd[1] |=> !right_out);

  // R7: a voice at its end word is low
  a_r7_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_done[0] |-> !left_out) and (voice_done[1] |-> !right_out));

  // R7: a finished melody waits for the bass unless the tune is switched
  a_r7_left_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_done[0] && !voice_done[1] && !tune_restart) |=> voice_done[0]);

  // R7: a finished bass waits for the melody unless the tune is switched
  a_r7_right_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_done[1] && !voice_done[0] && !tune_restart) |=> voice_done[1]);
endmodule

bind tune_player tune_player_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .song_sel     (song_sel),
  .beat         (beat),
  .tune_restart (tune_restart),
  .voice_snd    (voice_snd),
  .voice_done   (voice_done),
  .voice_start  (voice_start),
  .left_out     (left_out),
  .right_out    (right_out)
);

// File: tb/sim_tune_player.sv
`timescale 1ns/1ps
module sim_tune_player;
  localparam int T     = 256;
  localparam int SHIFT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       song_sel = 1'b0;
  logic [1:0] octave_sel = 2'd0;
  logic       left_out, right_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tune_player #(.TICK_DIV(T), .DIV_SHIFT(SHIFT), .IDX_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .song_sel(song_sel), .octave_sel(octave_sel),
    .left_out(left_out), .right_out(right_out)
  );

  // R11 tune contents, the bench's own copy
  function automatic logic [7:0] word_at(int song, int side, int k);
    logic [7:0] m0 [5] = '{8'h07, 8'h4B, 8'hC2, 8'h79, 8'hFF};
    logic [7:0] b0 [5] = '{8'h05, 8'h95, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] m1 [5] = '{8'h26, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] b1 [5] = '{8'hB4, 8'h50, 8'hE0, 8'h33, 8'hFF};
    if (k > 4) return 8'hFF;
    if (song == 0) return side == 0 ? m0[k] : b0[k];
    return side == 0 ? m1[k] : b1[k];
  endfunction

  // R3 beats per length code
  function automatic int beats(logic [2:0] code);
    int tbl [8] = '{1, 2, 3, 4, 6, 8, 12, 16};
    return tbl[code];
  endfunction

  function automatic int voice_total(int song, int side);
    int s = 0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] w = word_at(song, side, k);
      if (w == 8'hFF) break;
      s += beats(w[2:0]) + 1;
    end
    return s;
  endfunction

  // R6 expected half period
  function automatic int exp_half(int pc, int lift, int oct);
    int b [12] = '{382204, 360750, 340507, 321419, 303361, 286336,
                   270270, 255102, 240778, 227273, 214518, 202478};
    int h = b[pc] / (1 << SHIFT);
    h = h / (1 << (oct + lift));
    return (h < 2) ? 2 : h;
  endfunction

  function automatic bit pick(int side);
    return side == 0 ? left_out : right_out;
  endfunction

  task automatic win(int side, int a, int b, bit active, string tag);
    int  tog = 0;
    bit  low_ok = 1'b1;
    bit  prev, cur;
    while (cyc < a + 8) @(negedge clk);
    prev = pick(side);
    if (prev) low_ok = 1'b0;
    while (cyc < b - 8) begin
      @(negedge clk);
      cur = pick(side);
      if (cur != prev) tog++;
      if (cur) low_ok = 1'b0;
      prev = cur;
    end
    checks++;
    if (active && tog == 0) begin
      fails++;
      $display("FAIL %s side%0d cycles %0d..%0d: toggles=%0d expected>0", tag, side, a, b, tog);
    end else if (!active && (tog != 0 || !low_ok)) begin
      fails++;
      $display("FAIL %s side%0d cycles %0d..%0d: toggles=%0d low=%0d expected toggles=0 low=1",
               tag, side, a, b, tog, low_ok);
    end
  endtask

  task automatic play_voice(int side, int song, int e, int loops, string first_tag);
    int t   = e;
    int lim = voice_total(song, 0) > voice_total(song, 1) ? voice_total(song, 0)
                                                          : voice_total(song, 1);
    for (int l = 0; l < loops; l++) begin
      int    s = 0;
      string pre = (l == 0) ? first_tag : "R8";
      for (int k = 0; k < 8; k++) begin
        logic [7:0] w = word_at(song, side, k);
        int d;
        if (w == 8'hFF) break;
        d = beats(w[2:0]);
        if (w[7:4] >= 12)
          win(side, t + s*T, t + (s+d)*T, 1'b0, {pre, " R5 rest"});
        else
          win(side, t + s*T, t + (s+d)*T, 1'b1, {pre, " R2 R3 R4 note"});
        win(side, t + (s+d)*T, t + (s+d+1)*T, 1'b0, {pre, " R3 gap"});
        s += d + 1;
      end
      if (s < lim) win(side, t + s*T, t + lim*T, 1'b0, {pre, " R7 wait"});
      t += lim*T + 1;
    end
  endtask

  task automatic measure(int side, int expect_half, string tag);
    int t0 = -1, t1 = -1;
    bit p, c;
    p = pick(side);
    while (t1 < 0) begin
      @(negedge clk);
      c = pick(side);
      if (c && !p) begin
        if (t0 < 0) t0 = cyc;
        else        t1 = cyc;
      end
      p = c;
    end
    checks++;
    if (t1 - t0 != 2*expect_half) begin
      fails++;
      $display("FAIL %s side%0d: edge spacing=%0d expected=%0d", tag, side, t1 - t0, 2*expect_half);
    end
  endtask

  // drive song_sel at a negedge; returns the cycle count right after the restart edge
  task automatic switch_song(bit s, output int e);
    @(negedge clk);
    song_sel = s;
    @(posedge clk);
    #1;
    e = cyc;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int e, oct, new_oct;
    void'($urandom(32'd5150));

    // R1: outputs low while reset is held
    repeat (6) begin
      @(negedge clk);
      checks++;
      if (left_out || right_out) begin
        fails++;
        $display("FAIL R1 reset: left=%0d right=%0d expected 0 0", left_out, right_out);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    e = cyc;
    // R1: the first note of tune 0 sounds right after reset
    fork
      win(0, e, e + 16*T, 1'b1, "R1 first melody note");
      win(1, e, e + 8*T,  1'b1, "R1 first bass note");
    join

    // R9: switch to tune 1 part way through tune 0, follow two full passes
    wait_until(cyc + 100 + ($urandom % 500));
    switch_song(1'b1, e);
    fork
      play_voice(0, 1, e, 2, "R9");
      play_voice(1, 1, e, 2, "R9");
    join

    // R9: switch back mid-note with a random octave
    wait_until(cyc + 300 + ($urandom % 900));
    octave_sel = 2'($urandom % 4);
    switch_song(1'b0, e);
    fork
      play_voice(0, 0, e, 1, "R9");
      play_voice(1, 0, e, 1, "R9");
    join

    // R6, R10: pitch under random octaves, lifted note, octave change mid-note
    for (int i = 0; i < 6; i++) begin
      oct = (i < 4) ? i : int'($urandom % 4);
      switch_song(1'b1, e);
      wait_until(e + 20);
      octave_sel = 2'(oct);
      switch_song(1'b0, e);
      wait_until(e + 40);
      fork
        measure(0, exp_half(0, 0, oct), "R6 melody C");
        measure(1, exp_half(0, 0, oct), "R6 bass C");
      join
      if (i % 2 == 1) begin
        new_oct = (oct + 1 + int'($urandom % 3)) % 4;
        wait_until(e + 1200);
        @(negedge clk);
        octave_sel = 2'(new_oct);
        wait_until(e + 1400);
        measure(0, exp_half(0, 0, new_oct), "R10 melody octave change");
        oct = new_oct;
      end
      wait_until(e + 17*T + 20);
      measure(0, exp_half(4, 1, oct), "R6 R2 lifted melody E");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule